// File: doc/BRIEF.md
# Error-Correcting Memory Port with Read-Modify-Write Stores

This block connects a load/store unit to a word-organised synchronous memory in which every 32-bit word is kept together with a 7-bit single-error-correcting, double-error-detecting checksum. Loads always fetch a whole word. Any one flipped bit is repaired on the way back, and any two flipped bits are reported. Stores compute the checksum before the write. A byte or halfword store cannot just overwrite part of a protected word, so the port reads the word, corrects it, merges the new lanes, re-encodes and writes the whole word back.

Faults are reported on two separate lines. A repairable fault pulses a correctable-error request, which the core may mask, and stores the word address in a register that stays readable until the next such fault. An unrepairable fault pulses a request meant for a non-maskable interrupt. The port never repairs the memory content by itself. Scrubbing is left to software.

The CPU side is a valid/ready handshake with a one-cycle completion pulse. The memory side has one enable, one write enable, a word address and 39-bit read and write buses, with read data one cycle after the enable.

Top module: `ecc_mem_port`

## Requirements
- R1: A load with no fault returns the stored 32-bit word on `rsp_rdata`. `rsp_valid` is high for one cycle after the second rising edge that follows the accepting edge, and neither error request is raised.
- R2: A load of a codeword with exactly one flipped bit returns the original data, at any of the 39 bit positions. The codeword layout is data in bits 31:0, six Hamming bits in 37:32 and overall parity in bit 38.
- R3: A correctable fault pulses `cerr_irq` for one cycle and loads `cerr_addr` with the word address (`req_addr[ADDR_W-1:2]`). `cerr_addr` keeps that value until the next correctable fault.
- R4: A load of a codeword with any two flipped bits pulses `ue_nmi` together with `rsp_valid`, and `cerr_irq` stays low.
- R5: A full-word store (`req_size`=2) issues exactly one memory write and no read, and completes one rising edge after acceptance.
- R6: A sub-word store reads the word, replaces only the addressed lanes and writes back the whole word with a fresh checksum. It completes three edges after acceptance. Size 0 takes `req_wdata[7:0]` into byte lane `req_addr[1:0]`. Size 1 takes `req_wdata[15:0]` into the halfword selected by `req_addr[1]`.
- R7: If the read phase of a sub-word store finds a correctable fault, the port merges into the corrected word, writes it back with a valid checksum and raises `cerr_irq`.
- R8: If the read phase of a sub-word store finds an uncorrectable fault, no write is issued, `ue_nmi` pulses with `rsp_valid`, and the operation ends two edges after acceptance.
- R9: `req_ready` is low from the accepting edge until the cycle in which `rsp_valid` is high.
- R10: A load that corrects a fault does not write memory, so loading the same word again reports the fault again.
- R11: While and after reset, `req_ready` is 1, and `rsp_valid`, `cerr_irq`, `ue_nmi`, `mem_en`, `mem_we` and `cerr_addr` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Port can accept a request |
| req_write | input | 1 | 1 for store, 0 for load |
| req_size | input | 2 | 0 byte, 1 halfword, 2 or 3 word |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | 32 | Store data, right-aligned |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 32 | Corrected load word |
| cerr_irq | output | 1 | Correctable-fault request pulse |
| cerr_addr | output | ADDR_W-2 | Word address of last correctable fault |
| ue_nmi | output | 1 | Uncorrectable-fault request pulse |
| mem_en | output | 1 | Memory access enable |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | ADDR_W-2 | Memory word address |
| mem_wdata | output | 39 | Codeword to write |
| mem_rdata | input | 39 | Codeword read, valid one cycle after enable |

## Verification
The hardest case to reach from the ports is a fault that shows up in the middle of a sub-word store. The read phase lasts only one internal cycle, and the CPU side never sees the codeword it reads. The bench holds the memory model itself, so between a full-word store and the following partial store it flips one or two chosen bits of the stored codeword. It then watches the write enable, the error pulses and a later load to see whether the write was merged over corrected data or abandoned. The same direct access lets it walk single flips over all 39 positions and double flips over every pair.

// File: rtl/ecc_port_pkg.sv
package ecc_port_pkg;

  localparam int DATA_W  = 32;
  localparam int HAM_W   = 6;
  localparam int CODE_W  = DATA_W + HAM_W + 1;
  localparam int LANES   = DATA_W / 8;

  localparam logic [1:0] SZ_BYTE = 2'd0;
  localparam logic [1:0] SZ_HALF = 2'd1;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_READ,
    ST_CHECK,
    ST_WRITE
  } port_state_e;

  // Hamming position (1-based, skipping powers of two) of data bit k
  function automatic int unsigned data_pos(input int unsigned k);
    int unsigned cnt;
    int unsigned res;
    cnt = 0;
    res = 0;
    for (int unsigned p = 3; p < 64; p++) begin
      if ((p & (p - 1)) != 0) begin
        if (cnt == k && res == 0) res = p;
        cnt++;
      end
    end
    return res;
  endfunction

  function automatic logic [HAM_W-1:0] ham_bits(input logic [DATA_W-1:0] d);
    logic [HAM_W-1:0] h;
    h = '0;
    for (int unsigned k = 0; k < DATA_W; k++) begin
      for (int unsigned i = 0; i < HAM_W; i++) begin
        if (((data_pos(k) >> i) & 1) == 1) h[i] = h[i] ^ d[k];
      end
    end
    return h;
  endfunction

endpackage

// File: rtl/ecc_enc.sv
module ecc_enc
  import ecc_port_pkg::*;
(
  input  logic [DATA_W-1:0] data,
  output logic [CODE_W-1:0] code
);
  logic [HAM_W-1:0] ham;

  always_comb begin
    ham  = ham_bits(data);
    code = {^{ham, data}, ham, data};
  end
endmodule

// File: rtl/ecc_dec.sv
module ecc_dec
  import ecc_port_pkg::*;
(
  input  logic [CODE_W-1:0] code,
  output logic [DATA_W-1:0] data_fix,
  output logic              err_corr,
  output logic              err_unc
);
  localparam logic [HAM_W-1:0] MAX_POS = HAM_W'(CODE_W - 1);

  logic [HAM_W-1:0] syn;
  logic             par;

  always_comb begin
    syn = ham_bits(code[DATA_W-1:0]) ^ code[DATA_W +: HAM_W];
    par = ^code;
    // odd parity: one flip, located by the syndrome when in range
    err_corr = par && (syn <= MAX_POS);
    err_unc  = (!par && syn != '0) || (par && syn > MAX_POS);
    for (int unsigned k = 0; k < DATA_W; k++) begin
      data_fix[k] = code[k] ^ (par && (int'(syn) == int'(data_pos(k))));
    end
  end
endmodule

// File: rtl/ecc_merge.sv
module ecc_merge
  import ecc_port_pkg::*;
(
  input  logic [DATA_W-1:0] old_word,
  input  logic [DATA_W-1:0] wdata,
  input  logic [1:0]        size,
  input  logic [1:0]        offset,
  output logic [DATA_W-1:0] merged
);
  logic [LANES-1:0]  be;
  logic [DATA_W-1:0] lane_data;

  always_comb begin
    case (size)
      SZ_BYTE: begin
        be        = 4'b0001 << offset;
        lane_data = {LANES{wdata[7:0]}};
      end
      SZ_HALF: begin
        be        = offset[1] ? 4'b1100 : 4'b0011;
        lane_data = {2{wdata[15:0]}};
      end
      default: begin
        be        = '1;
        lane_data = wdata;
      end
    endcase
  end

  for (genvar b = 0; b < LANES; b++) begin : g_lane
    assign merged[8*b +: 8] = be[b] ? lane_data[8*b +: 8] : old_word[8*b +: 8];
  end
endmodule

// File: rtl/ecc_mem_port.sv
module ecc_mem_port
  import ecc_port_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic                req_write,
  input  logic [1:0]          req_size,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic [DATA_W-1:0]   req_wdata,
  output logic                rsp_valid,
  output logic [DATA_W-1:0]   rsp_rdata,
  output logic                cerr_irq,
  output logic [ADDR_W-3:0]   cerr_addr,
  output logic                ue_nmi,
  output logic                mem_en,
  output logic                mem_we,
  output logic [ADDR_W-3:0]   mem_addr,
  output logic [CODE_W-1:0]   mem_wdata,
  input  logic [CODE_W-1:0]   mem_rdata
);
  localparam int WA_W = ADDR_W - 2;

  port_state_e       state_q;
  logic              write_q;
  logic [1:0]        size_q;
  logic [1:0]        off_q;
  logic [DATA_W-1:0] wdata_q;

  logic [DATA_W-1:0] dec_data;
  logic              dec_corr;
  logic              dec_unc;
  logic [DATA_W-1:0] mg_old, mg_wdata, mg_out;
  logic [1:0]        mg_size, mg_off;
  logic [CODE_W-1:0] enc_code;
  logic              idle;

  assign idle      = (state_q == ST_IDLE);
  assign req_ready = idle;

  ecc_dec u_dec (
    .code     (mem_rdata),
    .data_fix (dec_data),
    .err_corr (dec_corr),
    .err_unc  (dec_unc)
  );

  // in idle the merge sees the new request (full word), otherwise the latched one
  always_comb begin
    mg_old   = idle ? '0 : dec_data;
    mg_wdata = idle ? req_wdata : wdata_q;
    mg_size  = idle ? req_size : size_q;
    mg_off   = idle ? req_addr[1:0] : off_q;
  end

  ecc_merge u_merge (
    .old_word (mg_old),
    .wdata    (mg_wdata),
    .size     (mg_size),
    .offset   (mg_off),
    .merged   (mg_out)
  );

  ecc_enc u_enc (
    .data (mg_out),
    .code (enc_code)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      write_q   <= 1'b0;
      size_q    <= '0;
      off_q     <= '0;
      wdata_q   <= '0;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
      cerr_irq  <= 1'b0;
      cerr_addr <= '0;
      ue_nmi    <= 1'b0;
      mem_en    <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
    end else begin
      mem_en    <= 1'b0;
      mem_we    <= 1'b0;
      rsp_valid <= 1'b0;
      cerr_irq  <= 1'b0;
      ue_nmi    <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (req_valid) begin
            write_q  <= req_write;
            size_q   <= req_size;
            off_q    <= req_addr[1:0];
            wdata_q  <= req_wdata;
            mem_addr <= req_addr[ADDR_W-1:2];
            mem_en   <= 1'b1;
            if (req_write && req_size[1]) begin
              mem_we    <= 1'b1;
              mem_wdata <= enc_code;
              state_q   <= ST_WRITE;
            end else begin
              state_q   <= ST_READ;
            end
          end
        end
        ST_READ: state_q <= ST_CHECK;
        ST_CHECK: begin
          if (dec_unc) begin
            ue_nmi    <= 1'b1;
            rsp_valid <= 1'b1;
            rsp_rdata <= dec_data;
            state_q   <= ST_IDLE;
          end else begin
            cerr_irq <= dec_corr;
            if (dec_corr) cerr_addr <= mem_addr;
            if (write_q) begin
              mem_en    <= 1'b1;
              mem_we    <= 1'b1;
              mem_wdata <= enc_code;
              state_q   <= ST_WRITE;
            end else begin
              rsp_valid <= 1'b1;
              rsp_rdata <= dec_data;
              state_q   <= ST_IDLE;
            end
          end
        end
        default: begin
          rsp_valid <= 1'b1;
          state_q   <= ST_IDLE;
        end
      endcase
    end
  end

  // R4: the two fault kinds never fire together
  a_r4_one_kind: assert property (@(posedge clk) disable iff (rst)
    !(cerr_irq && ue_nmi));

  // R8: an uncorrectable fault is never accompanied by a memory access
  a_r8_no_write_on_ue: assert property (@(posedge clk) disable iff (rst)
    ue_nmi |-> !mem_en);

  // R9: no request is taken while a read is outstanding
  a_r9_busy_on_read: assert property (@(posedge clk) disable iff (rst)
    (mem_en && !mem_we) |-> !req_ready);

  // R5: every memory write completes on the next cycle
  a_r5_write_completes: assert property (@(posedge clk) disable iff (rst)
    (mem_en && mem_we) |=> rsp_valid);

  // R3: the fault address only moves with a correctable-fault pulse
  a_r3_addr_held: assert property (@(posedge clk) disable iff (rst)
    !cerr_irq |=> $stable(cerr_addr) || cerr_irq);

  // R1: completion is a single-cycle pulse
  a_r1_rsp_pulse: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid);

endmodule

// File: tb/ecc_mem_port_tb_top.sv
module ecc_mem_port_tb_top;
  localparam int AW = 8;
  localparam int WORDS = 1 << (AW - 2);

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [1:0]  req_size = 2'd2;
  logic [AW-1:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid;
  logic [31:0] rsp_rdata;
  logic        cerr_irq;
  logic [AW-3:0] cerr_addr;
  logic        ue_nmi;
  logic        mem_en, mem_we;
  logic [AW-3:0] mem_addr;
  logic [38:0] mem_wdata;
  logic [38:0] mem_rdata;
  logic [38:0] mem [WORDS];

  int nchk = 0;
  int nerr = 0;

  always #2.5 clk = ~clk;

  ecc_mem_port #(.ADDR_W(AW)) dut_i (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_size(req_size), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .cerr_irq(cerr_irq), .cerr_addr(cerr_addr), .ue_nmi(ue_nmi),
    .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  always @(posedge clk) begin
    if (mem_en) begin
      if (mem_we) mem[mem_addr] <= mem_wdata;
      mem_rdata <= mem[mem_addr];
    end
  end

  typedef struct packed {
    logic [31:0] init;
    logic [1:0]  off;
    logic [1:0]  size;
    logic [31:0] wd;
    logic [31:0] expw;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{32'h11223344, 2'd0, 2'd0, 32'h000000AB, 32'h112233AB},
    '{32'h11223344, 2'd1, 2'd0, 32'h000000AB, 32'h1122AB44},
    '{32'h11223344, 2'd2, 2'd0, 32'h000000AB, 32'h11AB3344},
    '{32'h11223344, 2'd3, 2'd0, 32'h000000AB, 32'hAB223344},
    '{32'h11223344, 2'd0, 2'd1, 32'h0000BEEF, 32'h1122BEEF},
    '{32'h11223344, 2'd2, 2'd1, 32'h0000BEEF, 32'hBEEF3344},
    '{32'h11223344, 2'd0, 2'd2, 32'hCAFEF00D, 32'hCAFEF00D},
    '{32'h11223344, 2'd3, 2'd0, 32'h000001FF, 32'hFF223344}
  };

  // results of the last operation
  logic [31:0] o_rdata;
  int o_cyc, o_cerr, o_nmi, o_nwr;
  logic o_rdy_bad;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic run_op(input logic wr, input logic [1:0] sz, input logic [AW-1:0] a,
                        input logic [31:0] wd);
    logic done;
    done = 1'b0;
    o_cyc = 0; o_cerr = 0; o_nmi = 0; o_nwr = 0; o_rdy_bad = 1'b0;
    req_valid = 1'b1; req_write = wr; req_size = sz; req_addr = a; req_wdata = wd;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    for (int c = 1; c <= 20 && !done; c++) begin
      if (c > 1) @(negedge clk);
      if (mem_en && mem_we) o_nwr++;
      if (cerr_irq) o_cerr++;
      if (ue_nmi) o_nmi++;
      if (rsp_valid) begin
        done = 1'b1;
        o_cyc = c;
        o_rdata = rsp_rdata;
      end else if (req_ready) begin
        o_rdy_bad = 1'b1;
      end
    end
    if (!done) chk("R9 operation timeout", 1, 0);
  endtask

  initial begin
    logic [31:0] pat;
    logic [AW-3:0] last_w;
    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11 reset outputs", {req_ready, rsp_valid, cerr_irq, ue_nmi, mem_en, mem_we},
        6'b100000);
    chk("R11 reset cerr_addr", cerr_addr, 0);
    rst = 1'b0;
    @(negedge clk);

    // R5 full store, R1 clean load
    run_op(1'b1, 2'd2, 8'h0C, 32'hA5C30F96);
    chk("R5 full store latency", o_cyc, 2);
    chk("R5 full store writes", o_nwr, 1);
    chk("R9 ready low during store", o_rdy_bad, 0);
    run_op(1'b0, 2'd2, 8'h0C, 32'h0);
    chk("R1 clean load data", o_rdata, 32'hA5C30F96);
    chk("R1 clean load latency", o_cyc, 3);
    chk("R1 clean load no errors", {o_cerr, o_nmi}, 0);
    chk("R10 load issues no write", o_nwr, 0);

    // R6 vector table of lane merges
    foreach (VECS[v]) begin
      run_op(1'b1, 2'd2, 8'h14, VECS[v].init);
      run_op(1'b1, VECS[v].size, {6'd5, VECS[v].off}, VECS[v].wd);
      chk("R6 store latency", o_cyc, VECS[v].size[1] ? 2 : 4);
      chk("R6 single write", o_nwr, 1);
      chk("R9 ready low during merge", o_rdy_bad, 0);
      run_op(1'b0, 2'd2, 8'h14, 32'h0);
      chk("R6 merged word", o_rdata, VECS[v].expw);
      chk("R6 merged word clean", {o_cerr, o_nmi}, 0);
    end

    // R2/R3/R10 single flips at every position
    last_w = '0;
    for (int i = 0; i < 39; i++) begin
      logic [AW-3:0] w;
      w = AW'(16 + (i % 16)) >> 2 == 0 ? '0 : (AW-2)'(16 + (i % 16));
      pat = 32'h13579BDF ^ (32'h01010101 * i);
      run_op(1'b1, 2'd2, {w, 2'b00}, pat);
      mem[w][i] = ~mem[w][i];
      run_op(1'b0, 2'd2, {w, 2'b00}, 32'h0);
      chk("R2 corrected data", o_rdata, pat);
      chk("R3 correctable pulse", {o_cerr, o_nmi}, {32'd1, 32'd0});
      chk("R3 fault address", cerr_addr, w);
      run_op(1'b0, 2'd2, {w, 2'b00}, 32'h0);
      chk("R10 fault still in memory", o_cerr, 1);
      last_w = w;
    end

    // R4 every pair of flips
    run_op(1'b1, 2'd2, {6'd40, 2'b00}, 32'hDEADBEEF);
    for (int i = 0; i < 39; i++) begin
      for (int j = i + 1; j < 39; j++) begin
        mem[40][i] = ~mem[40][i];
        mem[40][j] = ~mem[40][j];
        run_op(1'b0, 2'd2, {6'd40, 2'b00}, 32'h0);
        chk("R4 double fault flags", {o_nmi, o_cerr}, {32'd1, 32'd0});
        mem[40][i] = ~mem[40][i];
        mem[40][j] = ~mem[40][j];
      end
    end
    chk("R3 address held over other faults", cerr_addr, last_w);

    // R7 correctable fault during merge
    run_op(1'b1, 2'd2, {6'd50, 2'b00}, 32'h01234567);
    mem[50][9] = ~mem[50][9];
    run_op(1'b1, 2'd1, {6'd50, 2'b10}, 32'h0000BEEF);
    chk("R7 merge with fault latency", o_cyc, 4);
    chk("R7 merge with fault writes", o_nwr, 1);
    chk("R7 merge raises cerr", {o_cerr, o_nmi}, {32'd1, 32'd0});
    chk("R3 address from merge", cerr_addr, 50);
    run_op(1'b0, 2'd2, {6'd50, 2'b00}, 32'h0);
    chk("R7 corrected merged word", o_rdata, 32'hBEEF4567);
    chk("R7 written back clean", {o_cerr, o_nmi}, 0);

    // R8 uncorrectable fault during merge
    run_op(1'b1, 2'd2, {6'd51, 2'b00}, 32'h89ABCDEF);
    mem[51][0] = ~mem[51][0];
    mem[51][35] = ~mem[51][35];
    run_op(1'b1, 2'd0, {6'd51, 2'b01}, 32'h00000055);
    chk("R8 abandoned latency", o_cyc, 3);
    chk("R8 no write", o_nwr, 0);
    chk("R8 nmi raised", {o_nmi, o_cerr}, {32'd1, 32'd0});
    run_op(1'b0, 2'd2, {6'd51, 2'b00}, 32'h0);
    chk("R8 memory left untouched", o_nmi, 1);
    chk("R4 uncorrectable load latency", o_cyc, 3);

    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nchk++;
    nerr++;
    $display("FAIL watchdog R9 actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end
endmodule